// File: doc/BRIEF.md
# Decoupled Memory Streaming Unit

The unit stands between a loop datapath and a single cache-line memory port. On a start pulse it walks a number of input streams and one output stream through memory. Each stream's element address is its base plus an index that counts up by one per iteration. Input-side address engines queue their addresses in request FIFOs. A request generator turns queued addresses into line reads. It only issues a read when room in that stream's data FIFO is already reserved. Returned lines carry a tag naming the stream and the element slot. The align logic uses the tag to extract the element and push it into the right data FIFO. The datapath consumes elements in order through a valid/ready pair per stream.

Results from the datapath enter an output data FIFO. They are paired with addresses from an output address engine and sent as single-element line writes with a one-hot element mask. One arbiter shares the memory port between reads and writes, alternating priority when both wait. Request and data FIFO depth is a parameter; depths of 2, 4 and 8 are supported.

Top module: `sdm_stream_unit`

## Requirements
- R1: For every input stream s, the k-th read request (k = 0 .. len-1) addresses element cfg_src_base[s] + k, in ascending order. The request carries line address element>>OFF_W, and its tag is {s, element[OFF_W-1:0]}, with the stream number in the upper bits and the element slot in the low OFF_W bits.
- R2: A response with tag {s, off} delivers bits [off*ELEM_W +: ELEM_W] of mem_rsp_data to input stream s.
- R3: Each input stream presents its elements to the datapath in address order. While src_valid is high and src_ready low, src_valid and that stream's src_data hold.
- R4: Reads issued to a stream but not yet taken by the datapath never exceed DEPTH, so no data FIFO is pushed while full. With the datapath stalled, exactly DEPTH reads per stream go out.
- R5: The k-th element accepted on the sink is written to element cfg_dst_base + k. The write carries line address element>>OFF_W, a one-hot wmask at the element slot, and the value at that slot. No other element in memory changes.
- R6: When a read and a write are both pending, the kind not granted at the previous grant goes first.
- R7: done goes high in the cycle after the final write is accepted and stays high until the next start. With cfg_len = 0, done goes high in the cycle after start and no request is made.
- R8: During and right after reset, mem_req_valid, src_valid and done are low and sink_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that latches the configuration and begins a run |
| cfg_len | input | CNT_W | Iterations in the run |
| cfg_src_base | input | NUM_IN*ADDR_W | Element base address of each input stream |
| cfg_dst_base | input | ADDR_W | Element base address of the output stream |
| done | output | 1 | All outputs of the run written |
| src_valid | output | NUM_IN | Element available on each input stream |
| src_ready | input | NUM_IN | Datapath takes an element from each stream |
| src_data | output | NUM_IN*ELEM_W | Element of each input stream |
| sink_valid | input | 1 | Datapath offers a result |
| sink_ready | output | 1 | Output FIFO has room |
| sink_data | input | ELEM_W | Result element |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | ADDR_W-OFF_W | Line address |
| mem_req_tag | output | SID_W+OFF_W | Read tag {stream, slot} |
| mem_req_wdata | output | ELEM_W*LINE_ELEMS | Write line, element replicated in every slot |
| mem_req_wmask | output | LINE_ELEMS | One-hot slot enable for writes |
| mem_rsp_valid | input | 1 | Read line returned |
| mem_rsp_tag | input | SID_W+OFF_W | Tag of the returned line |
| mem_rsp_data | input | ELEM_W*LINE_ELEMS | Returned line |

## Verification
The unit runs with stream bases at different slots within a line, so the tag-driven extraction and the one-hot write mask are exercised at every position. Memory that always accepts tests alternating grants under contention. Memory that accepts only one cycle in three, combined with a datapath that pauses, tests ordering under back-pressure. A long stall at the start of a run tells a credit-limited request generator apart from one that overruns the data FIFOs. A zero-length run and a one-element run cover the edges of the done logic.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

    typedef enum logic [1:0] {
        GNT_NONE  = 2'd0,
        GNT_READ  = 2'd1,
        GNT_WRITE = 2'd2
    } gnt_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sdm_fifo.sv
module sdm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW = sdm_pkg::idx_width(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign rdata   = store[rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) store[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/sdm_agu.sv
module sdm_agu #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  len,
    input  logic              full,
    output logic              push,
    output logic [ADDR_W-1:0] addr
);
    logic              active;
    logic [CNT_W-1:0]  idx, len_q;
    logic [ADDR_W-1:0] base_q;

    assign push = active && !full;
    assign addr = base_q + ADDR_W'(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            len_q  <= '0;
            base_q <= '0;
        end else if (start) begin
            active <= (len != '0);
            idx    <= '0;
            len_q  <= len;
            base_q <= base;
        end else if (push) begin
            idx <= idx + 1'b1;
            if (idx == len_q - 1'b1) active <= 1'b0;
        end
    end
endmodule

// File: rtl/sdm_arbiter.sv
module sdm_arbiter
    import sdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic wr_req,
    input  logic accept,
    output gnt_e grant
);
    logic prefer_wr;

    always_comb begin
        if (rd_req && wr_req) grant = prefer_wr ? GNT_WRITE : GNT_READ;
        else if (rd_req)      grant = GNT_READ;
        else if (wr_req)      grant = GNT_WRITE;
        else                  grant = GNT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)         prefer_wr <= 1'b0;
        else if (accept) prefer_wr <= (grant == GNT_READ);
    end
endmodule

// File: rtl/sdm_stream_unit.sv
module sdm_stream_unit
    import sdm_pkg::*;
#(
    parameter int NUM_IN     = 2,
    parameter int ELEM_W     = 8,
    parameter int LINE_ELEMS = 4,
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 16,
    parameter int DEPTH      = 4,
    localparam int OFF_W     = $clog2(LINE_ELEMS),
    localparam int LADDR_W   = ADDR_W - OFF_W,
    localparam int SID_W     = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int TAG_W     = SID_W + OFF_W,
    localparam int LINE_W    = ELEM_W * LINE_ELEMS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [CNT_W-1:0]         cfg_len,
    input  logic [NUM_IN*ADDR_W-1:0] cfg_src_base,
    input  logic [ADDR_W-1:0]        cfg_dst_base,
    output logic                     done,
    output logic [NUM_IN-1:0]        src_valid,
    input  logic [NUM_IN-1:0]        src_ready,
    output logic [NUM_IN*ELEM_W-1:0] src_data,
    input  logic                     sink_valid,
    output logic                     sink_ready,
    input  logic [ELEM_W-1:0]        sink_data,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic                     mem_req_write,
    output logic [LADDR_W-1:0]       mem_req_addr,
    output logic [TAG_W-1:0]         mem_req_tag,
    output logic [LINE_W-1:0]        mem_req_wdata,
    output logic [LINE_ELEMS-1:0]    mem_req_wmask,
    input  logic                     mem_rsp_valid,
    input  logic [TAG_W-1:0]         mem_rsp_tag,
    input  logic [LINE_W-1:0]        mem_rsp_data
);
    localparam int RES_W = $clog2(DEPTH + 1);

    // per-input-stream state
    logic [NUM_IN-1:0] rq_push, rq_full, rq_empty, rd_acc;
    logic [NUM_IN-1:0] df_push, df_full, df_empty, elig;
    logic [ADDR_W-1:0] rq_addr [NUM_IN];
    logic [ADDR_W-1:0] rq_head [NUM_IN];
    logic [ELEM_W-1:0] df_head [NUM_IN];
    logic [RES_W-1:0]  resv    [NUM_IN];

    // read selection and response alignment
    logic [SID_W-1:0]  rr, rd_sel;
    logic              rd_any;
    logic [ADDR_W-1:0] rd_addr;
    logic [SID_W-1:0]  rsp_sid;
    logic [OFF_W-1:0]  rsp_off;
    logic [ELEM_W-1:0] rsp_elem;

    // output side
    logic              oa_push, oa_full, oa_empty;
    logic [ADDR_W-1:0] oa_addr, oa_head;
    logic              od_full, od_empty;
    logic [ELEM_W-1:0] od_head;
    logic              wr_req, wr_acc, accept;
    logic [CNT_W-1:0]  wr_cnt, len_q;
    gnt_e              grant;

    assign rsp_sid = mem_rsp_tag[TAG_W-1:OFF_W];
    assign rsp_off = mem_rsp_tag[OFF_W-1:0];

    always_comb begin
        rsp_elem = '0;
        for (int e = 0; e < LINE_ELEMS; e++) begin
            if (rsp_off == OFF_W'(e)) rsp_elem = mem_rsp_data[e*ELEM_W +: ELEM_W];
        end
    end

    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            sdm_agu #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_agu (
                .clk(clk), .rst(rst), .start(start),
                .base(cfg_src_base[i*ADDR_W +: ADDR_W]), .len(cfg_len),
                .full(rq_full[i]), .push(rq_push[i]), .addr(rq_addr[i])
            );

            sdm_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_req_fifo (
                .clk(clk), .rst(rst),
                .push(rq_push[i]), .wdata(rq_addr[i]),
                .pop(rd_acc[i]), .rdata(rq_head[i]),
                .full(rq_full[i]), .empty(rq_empty[i])
            );

            assign df_push[i] = mem_rsp_valid && (rsp_sid == SID_W'(i));

            sdm_fifo #(.W(ELEM_W), .DEPTH(DEPTH)) u_data_fifo (
                .clk(clk), .rst(rst),
                .push(df_push[i]), .wdata(rsp_elem),
                .pop(src_ready[i]), .rdata(df_head[i]),
                .full(df_full[i]), .empty(df_empty[i])
            );

            assign src_valid[i]                  = !df_empty[i];
            assign src_data[i*ELEM_W +: ELEM_W]  = df_head[i];
            assign elig[i]   = !rq_empty[i] && (resv[i] < RES_W'(DEPTH));
            assign rd_acc[i] = accept && (grant == GNT_READ) && (rd_sel == SID_W'(i));

            // slots reserved: reads in flight plus elements waiting in the data FIFO
            always_ff @(posedge clk) begin
                if (rst) resv[i] <= '0;
                else case ({rd_acc[i], src_valid[i] && src_ready[i]})
                    2'b10:   resv[i] <= resv[i] + 1'b1;
                    2'b01:   resv[i] <= resv[i] - 1'b1;
                    default: resv[i] <= resv[i];
                endcase
            end
        end
    endgenerate

    // round-robin pick among eligible input streams, starting at rr
    always_comb begin
        int c;
        rd_any = 1'b0;
        rd_sel = '0;
        for (int k = NUM_IN - 1; k >= 0; k--) begin
            c = (int'(rr) + k) % NUM_IN;
            if (elig[c]) begin
                rd_any = 1'b1;
                rd_sel = SID_W'(c);
            end
        end
    end

    assign rd_addr = rq_head[rd_sel];

    always_ff @(posedge clk) begin
        if (rst) rr <= '0;
        else if (|rd_acc) rr <= (rd_sel == SID_W'(NUM_IN - 1)) ? '0 : rd_sel + 1'b1;
    end

    sdm_agu #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_out_agu (
        .clk(clk), .rst(rst), .start(start),
        .base(cfg_dst_base), .len(cfg_len),
        .full(oa_full), .push(oa_push), .addr(oa_addr)
    );

    sdm_fifo #(.W(ADDR_W), .DEPTH(DEPTH)) u_out_addr_fifo (
        .clk(clk), .rst(rst),
        .push(oa_push), .wdata(oa_addr),
        .pop(wr_acc), .rdata(oa_head),
        .full(oa_full), .empty(oa_empty)
    );

    sdm_fifo #(.W(ELEM_W), .DEPTH(DEPTH)) u_out_data_fifo (
        .clk(clk), .rst(rst),
        .push(sink_valid), .wdata(sink_data),
        .pop(wr_acc), .rdata(od_head),
        .full(od_full), .empty(od_empty)
    );

    assign sink_ready = !od_full;
    assign wr_req     = !oa_empty && !od_empty;

    sdm_arbiter u_arb (
        .clk(clk), .rst(rst),
        .rd_req(rd_any), .wr_req(wr_req),
        .accept(accept), .grant(grant)
    );

    assign mem_req_valid = (grant != GNT_NONE);
    assign mem_req_write = (grant == GNT_WRITE);
    assign accept        = mem_req_valid && mem_req_ready;
    assign wr_acc        = accept && mem_req_write;
    assign mem_req_addr  = mem_req_write ? oa_head[ADDR_W-1:OFF_W] : rd_addr[ADDR_W-1:OFF_W];
    assign mem_req_tag   = mem_req_write ? '0 : {rd_sel, rd_addr[OFF_W-1:0]};
    assign mem_req_wdata = {LINE_ELEMS{od_head}};

    always_comb begin
        for (int e = 0; e < LINE_ELEMS; e++) begin
            mem_req_wmask[e] = mem_req_write && (oa_head[OFF_W-1:0] == OFF_W'(e));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            wr_cnt <= '0;
            len_q  <= '0;
        end else if (start) begin
            done   <= (cfg_len == '0);
            wr_cnt <= '0;
            len_q  <= cfg_len;
        end else if (wr_acc) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (wr_cnt + 1'b1 == len_q) done <= 1'b1;
        end
    end
endmodule

// File: rtl/sdm_checker.sv
module sdm_checker #(
    parameter int NUM_IN     = 2,
    parameter int ELEM_W     = 8,
    parameter int LINE_ELEMS = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     done,
    input logic                     mem_req_valid,
    input logic                     mem_req_ready,
    input logic                     mem_req_write,
    input logic [LINE_ELEMS-1:0]    mem_req_wmask,
    input logic                     rd_pend,
    input logic                     wr_pend,
    input logic [NUM_IN-1:0]        src_valid,
    input logic [NUM_IN-1:0]        src_ready,
    input logic [NUM_IN*ELEM_W-1:0] src_data,
    input logic [NUM_IN-1:0]        df_push,
    input logic [NUM_IN-1:0]        df_full
);
    p_wmask_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> ($countones(mem_req_wmask) == 1));

    p_read_no_mask_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_write) |-> (mem_req_wmask == '0));

    p_write_after_read_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_req_valid && mem_req_ready && !mem_req_write) && rd_pend && wr_pend)
        |-> (mem_req_valid && mem_req_write));

    p_read_after_write_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(mem_req_valid && mem_req_ready && mem_req_write) && rd_pend && wr_pend)
        |-> (mem_req_valid && !mem_req_write));

    p_done_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(mem_req_valid && mem_req_ready && mem_req_write) || $past(start)));

    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
            p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
                df_push[i] |-> !df_full[i]);

            p_src_hold_r3: assert property (@(posedge clk) disable iff (rst)
                (src_valid[i] && !src_ready[i]) |=>
                (src_valid[i] && $stable(src_data[i*ELEM_W +: ELEM_W])));
        end
    endgenerate
endmodule

bind sdm_stream_unit sdm_checker #(
    .NUM_IN(NUM_IN), .ELEM_W(ELEM_W), .LINE_ELEMS(LINE_ELEMS)
) u_sdm_checker (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_wmask(mem_req_wmask),
    .rd_pend(rd_any), .wr_pend(wr_req),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .df_push(df_push), .df_full(df_full)
);

// File: tb/sdm_stream_unit_bench.sv
module sdm_stream_unit_bench;
    localparam int NUM_IN = 2, ELEM_W = 8, LINE_ELEMS = 4;
    localparam int ADDR_W = 10, CNT_W = 8, DEPTH = 4;
    localparam int LAT = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CNT_W-1:0] cfg_len = '0;
    logic [NUM_IN*ADDR_W-1:0] cfg_src_base = '0;
    logic [ADDR_W-1:0] cfg_dst_base = '0;
    logic done;
    logic [NUM_IN-1:0] src_valid;
    logic [NUM_IN-1:0] src_ready = '0;
    logic [NUM_IN*ELEM_W-1:0] src_data;
    logic sink_valid = 1'b0;
    logic sink_ready;
    logic [ELEM_W-1:0] sink_data = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic mem_req_write;
    logic [ADDR_W-3:0] mem_req_addr;
    logic [2:0] mem_req_tag;
    logic [31:0] mem_req_wdata;
    logic [3:0] mem_req_wmask;
    logic mem_rsp_valid = 1'b0;
    logic [2:0] mem_rsp_tag = '0;
    logic [31:0] mem_rsp_data = '0;

    sdm_stream_unit #(
        .NUM_IN(NUM_IN), .ELEM_W(ELEM_W), .LINE_ELEMS(LINE_ELEMS),
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
    ) u_sdm_stream_unit (
        .clk(clk), .rst(rst), .start(start), .cfg_len(cfg_len),
        .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base), .done(done),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .sink_valid(sink_valid), .sink_ready(sink_ready), .sink_data(sink_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_tag(mem_req_tag), .mem_req_wdata(mem_req_wdata),
        .mem_req_wmask(mem_req_wmask), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_tag(mem_rsp_tag), .mem_rsp_data(mem_rsp_data)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0, cycle = 0;
    logic [7:0] mem [0:1023];
    int q_tag[$], q_line[$], q_due[$];
    logic [7:0] exp_s0[$], exp_s1[$], exp_out[$];
    int nxt_rd[2], rd_issued[2];
    int wr_cnt = 0, sink_cnt = 0, obase_cur = 0, rdy_mode = 0;
    bit last_rd = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycle++;
        if (cycle == 150000) begin
            check(1'b0, "watchdog", cycle, 0);
            finish_run();
        end
    end

    // memory model and scoreboard of requests
    always @(negedge clk) begin : mem_model
        int sid, off, ea;
        logic [7:0] wv;
        if (rst) begin
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
        end else begin
            mem_req_ready = (rdy_mode == 0) ? 1'b1 : (cycle % 3 == 0);
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    off = 0;
                    for (int e = 0; e < 4; e++) if (mem_req_wmask[e]) off = e;
                    ea = int'(mem_req_addr) * 4 + off;
                    wv = mem_req_wdata[off*8 +: 8];
                    check(ea == obase_cur + wr_cnt, "R5 write address", ea, obase_cur + wr_cnt);
                    if (exp_out.size() > 0)
                        check(wv == exp_out.pop_front(), "R5 write value", wv, 0);
                    mem[ea] = wv;
                    wr_cnt++;
                    last_rd = 1'b0;
                end else begin
                    sid = int'(mem_req_tag) >> 2;
                    off = int'(mem_req_tag) & 3;
                    ea  = int'(mem_req_addr) * 4 + off;
                    check(ea == nxt_rd[sid], "R1 read address", ea, nxt_rd[sid]);
                    if (last_rd && (sink_cnt > wr_cnt))
                        check(1'b0, "R6 read granted over pending write", 1, 0);
                    else if (sink_cnt > wr_cnt)
                        check(1'b1, "R6", 0, 0);
                    nxt_rd[sid]++;
                    rd_issued[sid]++;
                    q_tag.push_back(int'(mem_req_tag));
                    q_line.push_back(int'(mem_req_addr));
                    q_due.push_back(cycle + LAT);
                    last_rd = 1'b1;
                end
            end
            if (q_due.size() > 0 && q_due[0] <= cycle) begin
                int ln;
                ln = q_line.pop_front();
                void'(q_due.pop_front());
                mem_rsp_tag = 3'(q_tag.pop_front());
                for (int e = 0; e < 4; e++) mem_rsp_data[e*8 +: 8] = mem[ln*4 + e];
                mem_rsp_valid = 1'b1;
            end else begin
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic run(input int b0, input int b1, input int ob, input int len,
                       input int mode, input int first_stall);
        logic [7:0] a, b;
        logic r;
        int t;
        rdy_mode = mode;
        for (int x = 0; x < 1024; x++) mem[x] = 8'(x * 37 + 11);
        for (int k = -1; k <= len; k++) mem[ob + k] = 8'hEE;
        exp_s0.delete(); exp_s1.delete(); exp_out.delete();
        for (int k = 0; k < len; k++) begin
            exp_s0.push_back(mem[b0 + k]);
            exp_s1.push_back(mem[b1 + k]);
            exp_out.push_back(8'(mem[b0 + k] + mem[b1 + k]));
        end
        nxt_rd[0] = b0; nxt_rd[1] = b1;
        rd_issued[0] = 0; rd_issued[1] = 0;
        wr_cnt = 0; sink_cnt = 0; obase_cur = ob;

        @(negedge clk);
        cfg_len = CNT_W'(len);
        cfg_src_base = {ADDR_W'(b1), ADDR_W'(b0)};
        cfg_dst_base = ADDR_W'(ob);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        if (len == 0) begin
            check(done == 1'b1, "R7 done after zero-length start", done, 1);
            repeat (20) @(negedge clk);
            check(rd_issued[0] + rd_issued[1] + wr_cnt == 0, "R7 no requests for zero length",
                  rd_issued[0] + rd_issued[1] + wr_cnt, 0);
            return;
        end

        check(done == 1'b0, "R7 done cleared by start", done, 0);
        if (first_stall > 0) begin
            repeat (first_stall) @(negedge clk);
            check(rd_issued[0] == DEPTH, "R4 stream0 reads under stall", rd_issued[0], DEPTH);
            check(rd_issued[1] == DEPTH, "R4 stream1 reads under stall", rd_issued[1], DEPTH);
            check(src_valid == 2'b11, "R4 data buffered", src_valid, 3);
        end

        // datapath model: sink = src0 + src1
        for (int n = 0; n < len; n++) begin
            if (mode == 1 && n % 3 == 1) repeat (2) @(negedge clk);
            while (src_valid != 2'b11) @(negedge clk);
            a = src_data[7:0];
            b = src_data[15:8];
            check(a == exp_s0[0], "R2 R3 stream0 element", a, exp_s0[0]);
            check(b == exp_s1[0], "R2 R3 stream1 element", b, exp_s1[0]);
            void'(exp_s0.pop_front());
            void'(exp_s1.pop_front());
            src_ready = 2'b11;
            @(negedge clk);
            src_ready = 2'b00;
            sink_valid = 1'b1;
            sink_data = 8'(a + b);
            forever begin
                r = sink_ready;
                @(negedge clk);
                if (r) break;
            end
            sink_valid = 1'b0;
            sink_cnt++;
        end

        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(done == 1'b1, "R7 done after last write", done, 1);
        check(wr_cnt == len, "R7 done not before final write", wr_cnt, len);
        for (int k = 0; k < len; k++)
            check(mem[ob + k] == 8'(mem[b0 + k] + mem[b1 + k]), "R5 stored result",
                  mem[ob + k], 8'(mem[b0 + k] + mem[b1 + k]));
        check(mem[ob - 1] == 8'hEE, "R5 element below untouched", mem[ob - 1], 8'hEE);
        check(mem[ob + len] == 8'hEE, "R5 element above untouched", mem[ob + len], 8'hEE);
        check(rd_issued[0] == len && rd_issued[1] == len, "R1 read count",
              rd_issued[0] + rd_issued[1], 2 * len);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R7 done held", done, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(mem_req_valid == 1'b0, "R8 no request in reset", mem_req_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(mem_req_valid == 1'b0, "R8 no request after reset", mem_req_valid, 0);
        check(src_valid == 2'b00, "R8 src_valid low", src_valid, 0);
        check(done == 1'b0, "R8 done low", done, 0);
        check(sink_ready == 1'b1, "R8 sink_ready high", sink_ready, 1);

        run(5, 100, 600, 12, 0, 0);
        run(202, 301, 701, 9, 1, 60);
        run(0, 0, 800, 0, 0, 0);
        run(40, 43, 903, 1, 0, 0);
        run(400, 450, 513, 20, 1, 0);
        run(2, 7, 250, 16, 0, 0);

        finish_run();
    end
endmodule